// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This unit takes two single-precision (binary32) operands and returns one of them as the minimum or maximum. It can compare them as signed values or by absolute value. Nothing is rounded. The result is always one of the two input encodings, or a NaN input with its quiet bit set. A two-bit operation code picks min, max, min-by-magnitude or max-by-magnitude. A two-bit policy code picks how NaN inputs are handled. In the first policy a quiet NaN counts as missing data and a signalling NaN wins. In the second, every NaN propagates. In the third, every NaN counts as missing data.

Inside the unit, values are ordered as sign-magnitude integers. Negative zero therefore sits below positive zero, and two NaNs are ordered by their bit patterns, which makes the choice between two NaNs independent of operand order. A combinational decision stage labels each request with one outcome. The outcomes are DEC_NUM (numeric choice), DEC_TAKE_A and DEC_TAKE_B (return that operand as it is), DEC_QUIET_A and DEC_QUIET_B (return that operand quieted), and DEC_QUIET_PICK (return the ordered choice between two NaNs, quieted). A one-stage register then captures the result, the invalid flag and the valid strobe. There is one cycle of latency.

Top module: `fmm_unit`

## Requirements
- R1: With two non-NaN operands, op code 0 (minimum) returns the lower operand and op code 1 (maximum) returns the higher one. Infinities are ordered like other values.
- R2: Negative zero ranks strictly below positive zero. min(+0,-0) gives 0x80000000 and max(+0,-0) gives 0x00000000, whichever operand holds which zero.
- R3: Op code 2 returns the operand with the smaller absolute value and op code 3 returns the one with the larger absolute value. When the absolute values are equal, op 2 gives the op 0 result and op 3 gives the op 1 result.
- R4: Under policy 0, a quiet NaN paired with a number returns the number and leaves the invalid flag clear.
- R5: Under policy 0, a signalling NaN in operand A returns A quieted, whatever B holds. Otherwise a signalling NaN in B returns B quieted, even when A is a quiet NaN.
- R6: Under policy 1, any NaN input gives a quiet NaN result. A single NaN input is returned quieted.
- R7: Under policy 2, the result is the numeric operand whenever exactly one operand is a number.
- R8: When both operands are NaN and the R5 rule does not apply, the minimum-type ops (0, 2) return A if A's bits rank at or below B's in sign-magnitude order, and otherwise B. The maximum-type ops (1, 3) return A if B ranks at or below A, and otherwise B. The chosen NaN is quieted.
- R9: A NaN has exponent all ones and a non-zero fraction. It is quiet when bit 22 is 1. Quieting sets bit 22 and keeps the sign and all other bits, so the result is never a signalling NaN.
- R10: The invalid flag is 1 exactly when either operand is a signalling NaN, under every policy.
- R11: Result, flag and valid appear one cycle after an input with valid high. A cycle with valid low clears the output valid and holds the result. Synchronous reset clears valid, result and flag to 0.
- R12: Policy code 3 behaves exactly like policy 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_a | input | 32 | First operand (A) |
| in_b | input | 32 | Second operand (B) |
| in_op | input | 2 | 0 min, 1 max, 2 min magnitude, 3 max magnitude |
| in_pol | input | 2 | 0 quiet-NaN missing, 1 propagate, 2 all-NaN missing, 3 as 0 |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Selected value |
| out_invalid | output | 1 | Signalling NaN seen |

## Verification
The assertions check on every cycle that valid follows the request one cycle later and that the result is held when no request arrives. They also check that the flag tracks signalling inputs, that the output is never a signalling NaN, and that a numeric pair yields one of its own operands. Each NaN policy is held to its coarse outcome: propagate yields a NaN, and all-missing yields a number when one is offered. The bench's scenarios show which operand is chosen. That covers signed-zero ordering, ties between equal magnitudes, signalling-NaN priority, and the ordered choice between two NaNs, including the check that swapping the operands does not change that choice.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    typedef enum logic [1:0] {
        OP_MIN    = 2'd0,
        OP_MAX    = 2'd1,
        OP_MINMAG = 2'd2,
        OP_MAXMAG = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        POL_QMISS   = 2'd0,
        POL_PROP    = 2'd1,
        POL_ALLMISS = 2'd2,
        POL_SPARE   = 2'd3
    } pol_e;

    typedef enum logic [2:0] {
        DEC_NUM,
        DEC_TAKE_A,
        DEC_TAKE_B,
        DEC_QUIET_A,
        DEC_QUIET_B,
        DEC_QUIET_PICK
    } dec_e;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output logic                  is_nan,
    output logic                  is_snan
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &val[W-2:FRAC_W];
        frac_nz  = |val[FRAC_W-1:0];
        is_nan   = exp_ones && frac_nz;
        is_snan  = is_nan && !val[FRAC_W-1];
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output logic                  a_below_b,
    output logic                  b_below_a,
    output logic                  mag_a_below,
    output logic                  mag_b_below
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [W-1:0] key_a;
    logic [W-1:0] key_b;

    // Sign-magnitude values mapped onto a monotonic unsigned key
    always_comb begin
        key_a       = a[W-1] ? ~a : {1'b1, a[W-2:0]};
        key_b       = b[W-1] ? ~b : {1'b1, b[W-2:0]};
        a_below_b   = key_a < key_b;
        b_below_a   = key_b < key_a;
        mag_a_below = a[W-2:0] < b[W-2:0];
        mag_b_below = b[W-2:0] < a[W-2:0];
    end
endmodule

// File: rtl/fmm_decide.sv
module fmm_decide
    import fmm_pkg::*;
(
    input  op_e  op,
    input  pol_e pol,
    input  logic nan_a,
    input  logic snan_a,
    input  logic nan_b,
    input  logic snan_b,
    input  logic a_below_b,
    input  logic b_below_a,
    input  logic mag_a_below,
    input  logic mag_b_below,
    output dec_e dec,
    output logic plain_pick_a,
    output logic num_pick_a,
    output logic invalid
);
    logic min_type;

    always_comb begin
        min_type     = (op == OP_MIN) || (op == OP_MINMAG);
        plain_pick_a = min_type ? !b_below_a : !a_below_b;
        unique case (op)
            OP_MIN, OP_MAX: num_pick_a = plain_pick_a;
            OP_MINMAG:      num_pick_a = mag_a_below ? 1'b1 :
                                         (mag_b_below ? 1'b0 : plain_pick_a);
            OP_MAXMAG:      num_pick_a = mag_b_below ? 1'b1 :
                                         (mag_a_below ? 1'b0 : plain_pick_a);
            default:        num_pick_a = plain_pick_a;
        endcase
        invalid = snan_a || snan_b;
    end

    always_comb begin
        dec = DEC_NUM;
        unique case (pol)
            POL_PROP: begin
                if (nan_a && nan_b)  dec = DEC_QUIET_PICK;
                else if (nan_a)      dec = DEC_QUIET_A;
                else if (nan_b)      dec = DEC_QUIET_B;
                else                 dec = DEC_NUM;
            end
            POL_ALLMISS: begin
                if (nan_a && nan_b)  dec = DEC_QUIET_PICK;
                else if (nan_a)      dec = DEC_TAKE_B;
                else if (nan_b)      dec = DEC_TAKE_A;
                else                 dec = DEC_NUM;
            end
            POL_QMISS, POL_SPARE: begin
                if (snan_a)              dec = DEC_QUIET_A;
                else if (snan_b)         dec = DEC_QUIET_B;
                else if (nan_a && nan_b) dec = DEC_QUIET_PICK;
                else if (nan_a)          dec = DEC_TAKE_B;
                else if (nan_b)          dec = DEC_TAKE_A;
                else                     dec = DEC_NUM;
            end
            default: dec = DEC_NUM;
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] in_a,
    input  logic [EXP_W+FRAC_W:0] in_b,
    input  logic [1:0]            in_op,
    input  logic [1:0]            in_pol,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_result,
    output logic                  out_invalid
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

    logic nan_a, snan_a, nan_b, snan_b;
    logic a_below_b, b_below_a, mag_a_below, mag_b_below;
    logic plain_pick_a, num_pick_a, invalid_c;
    dec_e dec;
    logic [W-1:0] sel_c;

    fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .val(in_a), .is_nan(nan_a), .is_snan(snan_a)
    );

    fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .val(in_b), .is_nan(nan_b), .is_snan(snan_b)
    );

    fmm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
        .a(in_a), .b(in_b),
        .a_below_b(a_below_b), .b_below_a(b_below_a),
        .mag_a_below(mag_a_below), .mag_b_below(mag_b_below)
    );

    fmm_decide u_decide (
        .op(op_e'(in_op)), .pol(pol_e'(in_pol)),
        .nan_a(nan_a), .snan_a(snan_a), .nan_b(nan_b), .snan_b(snan_b),
        .a_below_b(a_below_b), .b_below_a(b_below_a),
        .mag_a_below(mag_a_below), .mag_b_below(mag_b_below),
        .dec(dec), .plain_pick_a(plain_pick_a), .num_pick_a(num_pick_a),
        .invalid(invalid_c)
    );

    // Output selection driven by the decision outcome
    always_comb begin
        unique case (dec)
            DEC_NUM:        sel_c = num_pick_a ? in_a : in_b;
            DEC_TAKE_A:     sel_c = in_a;
            DEC_TAKE_B:     sel_c = in_b;
            DEC_QUIET_A:    sel_c = in_a | QBIT;
            DEC_QUIET_B:    sel_c = in_b | QBIT;
            DEC_QUIET_PICK: sel_c = (plain_pick_a ? in_a : in_b) | QBIT;
            default:        sel_c = in_a;
        endcase
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= sel_c;
                out_invalid <= invalid_c;
            end
        end
    end
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] in_a,
    input logic [EXP_W+FRAC_W:0] in_b,
    input logic [1:0]            in_op,
    input logic [1:0]            in_pol,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] out_result,
    input logic                  out_invalid
);
    localparam int W = 1 + EXP_W + FRAC_W;

    function automatic logic nan_f(input logic [W-1:0] v);
        return (&v[W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
    endfunction

    function automatic logic snan_f(input logic [W-1:0] v);
        return nan_f(v) && !v[FRAC_W-1];
    endfunction

    logic a_nan, b_nan, any_snan, r_nan, r_snan;
    assign a_nan    = nan_f(in_a);
    assign b_nan    = nan_f(in_b);
    assign any_snan = snan_f(in_a) || snan_f(in_b);
    assign r_nan    = nan_f(out_result);
    assign r_snan   = snan_f(out_result);

    p_valid_rise_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result) && $stable(out_invalid));
    p_flag_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_invalid == $past(any_snan));
    p_never_snan_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !r_snan);
    p_num_operand_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && !a_nan && !b_nan |=>
            (out_result == $past(in_a)) || (out_result == $past(in_b)));
    p_prop_nan_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_pol == 2'd1 && (a_nan || b_nan) |=> r_nan);
    p_allmiss_num_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_pol == 2'd2 && (a_nan != b_nan) |=> !r_nan);
endmodule

bind fmm_unit fmm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fmm_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_op(in_op), .in_pol(in_pol), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid)
);

// File: tb/tb_fmm_unit.sv
module tb_fmm_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_a, in_b;
    logic [1:0]  in_op, in_pol;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fmm_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op(in_op), .in_pol(in_pol), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [31:0] v);
        return is_nan(v) && (v[22] == 1'b0);
    endfunction

    // x strictly below y in sign-magnitude order
    function automatic bit below(input logic [31:0] x, input logic [31:0] y);
        if (x[31] != y[31]) return x[31];
        if (!x[31]) return x[30:0] < y[30:0];
        return x[30:0] > y[30:0];
    endfunction

    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] op, input logic [1:0] pol);
        logic [31:0] plain, num, r;
        bit mn, f;
        logic [1:0] p;
        mn = (op == 2'd0) || (op == 2'd2);
        p  = (pol == 2'd3) ? 2'd0 : pol;
        f  = is_snan(a) || is_snan(b);
        plain = mn ? (below(b, a) ? b : a) : (below(a, b) ? b : a);
        case (op)
            2'd2: num = (a[30:0] < b[30:0]) ? a : (b[30:0] < a[30:0]) ? b : plain;
            2'd3: num = (a[30:0] > b[30:0]) ? a : (b[30:0] > a[30:0]) ? b : plain;
            default: num = plain;
        endcase
        if (p == 2'd0 && is_snan(a))           r = a | 32'h0040_0000;
        else if (p == 2'd0 && is_snan(b))      r = b | 32'h0040_0000;
        else if (is_nan(a) && is_nan(b))       r = plain | 32'h0040_0000;
        else if (is_nan(a))                    r = (p == 2'd1) ? (a | 32'h0040_0000) : b;
        else if (is_nan(b))                    r = (p == 2'd1) ? (b | 32'h0040_0000) : a;
        else                                   r = num;
        return {f, r};
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                       input logic [1:0] pol, input logic [31:0] exp_r, input bit exp_f,
                       input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_op = op; in_pol = pol;
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        if (out_valid !== 1'b1 || out_result !== exp_r || out_invalid !== exp_f) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h op=%0d pol=%0d actual v=%b r=%h f=%b expected v=1 r=%h f=%b",
                     tag, a, b, op, pol, out_valid, out_result, out_invalid, exp_r, exp_f);
        end
    endtask

    task automatic run_model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                             input logic [1:0] pol, input string tag);
        logic [32:0] e;
        e = model(a, b, op, pol);
        run(a, b, op, pol, e[31:0], e[32], tag);
    endtask

    function automatic logic [31:0] pick_val(input logic [31:0] other);
        int k;
        k = $urandom_range(0, 9);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return {$urandom_range(0, 1) == 1, 8'hFF, 1'b1, 22'($urandom)};
            3: return {$urandom_range(0, 1) == 1, 8'hFF, 1'b0, 22'($urandom_range(1, 4194303))};
            4: return {other[31] ^ 1'b1, other[30:0]};
            5: return {$urandom_range(0, 1) == 1, 8'hFF, 23'h0};
            6: return other;
            default: return $urandom;
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b,
                                     input logic [1:0] op, input logic [1:0] pol);
        if (is_nan(a) && is_nan(b)) return "R8";
        if (is_snan(a) || is_snan(b)) return "R10";
        if (is_nan(a) || is_nan(b)) return (pol == 2'd1) ? "R6" : ((pol == 2'd2) ? "R7" : "R4");
        if (op[1]) return "R3";
        return "R1";
    endfunction

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_r;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_op = '0; in_pol = '0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== 32'h0 || out_invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: actual v=%b r=%h f=%b expected 0/0/0",
                     out_valid, out_result, out_invalid);
        end
        rst = 1'b0;

        run(32'h3F80_0000, 32'h4000_0000, 2'd1, 2'd0, 32'h4000_0000, 0, "R1 max");
        run(32'hC040_0000, 32'h4000_0000, 2'd0, 2'd0, 32'hC040_0000, 0, "R1 min");
        run(32'h7F80_0000, 32'hFF80_0000, 2'd1, 2'd0, 32'h7F80_0000, 0, "R1 inf");
        run(32'h0000_0000, 32'h8000_0000, 2'd1, 2'd0, 32'h0000_0000, 0, "R2 max");
        run(32'h8000_0000, 32'h0000_0000, 2'd1, 2'd0, 32'h0000_0000, 0, "R2 max swap");
        run(32'h0000_0000, 32'h8000_0000, 2'd0, 2'd0, 32'h8000_0000, 0, "R2 min");
        run(32'h8000_0000, 32'h0000_0000, 2'd0, 2'd0, 32'h8000_0000, 0, "R2 min swap");
        run(32'hBF80_0000, 32'h4000_0000, 2'd2, 2'd0, 32'hBF80_0000, 0, "R3 minmag");
        run(32'hC040_0000, 32'h4000_0000, 2'd3, 2'd0, 32'hC040_0000, 0, "R3 maxmag");
        run(32'hC000_0000, 32'h4000_0000, 2'd2, 2'd0, 32'hC000_0000, 0, "R3 tie min");
        run(32'h4000_0000, 32'hC000_0000, 2'd3, 2'd0, 32'h4000_0000, 0, "R3 tie max");
        run(32'h3F80_0000, 32'h7FC0_0000, 2'd1, 2'd0, 32'h3F80_0000, 0, "R4");
        run(32'h7FC0_0000, 32'hC040_0000, 2'd0, 2'd0, 32'hC040_0000, 0, "R4 swap");
        run(32'h7F80_0001, 32'h3F80_0000, 2'd1, 2'd0, 32'h7FC0_0001, 1, "R5 snan a");
        run(32'h7FC0_0000, 32'h7F80_0005, 2'd1, 2'd0, 32'h7FC0_0005, 1, "R5 q vs s");
        run(32'h7F80_0002, 32'h7F80_0009, 2'd0, 2'd0, 32'h7FC0_0002, 1, "R5 a first");
        run(32'h3F80_0000, 32'h7FC0_0000, 2'd1, 2'd1, 32'h7FC0_0000, 0, "R6 qnan");
        run(32'h7F80_0003, 32'h4000_0000, 2'd0, 2'd1, 32'h7FC0_0003, 1, "R6 snan");
        run(32'h3F80_0000, 32'h7F80_0003, 2'd1, 2'd2, 32'h3F80_0000, 1, "R7 snan");
        run(32'h7FC0_0000, 32'hC040_0000, 2'd0, 2'd2, 32'hC040_0000, 0, "R7 qnan");
        run(32'h7FC0_0001, 32'hFFC0_0000, 2'd1, 2'd1, 32'h7FC0_0001, 0, "R8 max");
        run(32'h7FC0_0001, 32'hFFC0_0000, 2'd0, 2'd1, 32'hFFC0_0000, 0, "R8 min");
        run(32'h7FC0_0003, 32'h7FC0_0001, 2'd0, 2'd2, 32'h7FC0_0001, 0, "R8 order");
        run(32'h7FC0_0001, 32'h7FC0_0003, 2'd0, 2'd2, 32'h7FC0_0001, 0, "R8 swapped");
        run(32'h7F80_0004, 32'h7FC0_0000, 2'd1, 2'd1, 32'h7FC0_0000, 1, "R8 s<q max");
        run(32'h7F80_0004, 32'h7FC0_0000, 2'd0, 2'd1, 32'h7FC0_0004, 1, "R8 s<q min");
        run(32'hFF80_0123, 32'h3F80_0000, 2'd1, 2'd1, 32'hFFC0_0123, 1, "R9 payload");
        run(32'h3F80_0000, 32'h7FC0_0000, 2'd1, 2'd3, 32'h3F80_0000, 0, "R12 qnan");
        run(32'h7F80_0001, 32'h7FC0_0000, 2'd1, 2'd3, 32'h7FC0_0001, 1, "R12 snan");
        run(32'h4000_0000, 32'h3F80_0000, 2'd3, 2'd1, 32'h4000_0000, 0, "R10 no flag");

        // R11: idle cycle holds result and drops valid
        last_r = out_result;
        @(negedge clk);
        in_valid = 1'b0; in_a = 32'h1234_5678; in_b = 32'h7F80_0001;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== last_r || out_invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 hold: actual v=%b r=%h f=%b expected v=0 r=%h f=0",
                     out_valid, out_result, out_invalid, last_r);
        end

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            logic [1:0] op, pol;
            a   = pick_val($urandom);
            b   = pick_val(a);
            op  = 2'($urandom_range(0, 3));
            pol = 2'($urandom_range(0, 3));
            run_model(a, b, op, pol, tag_of(a, b, op, pol));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule